// File: doc/BRIEF.md
# Correlator Lag Result Framer

The block collects the accumulated lag results of up to `NUM_SUB` sub-arrays and packs them into one output frame per dump slot. A one-cycle `slotTick` opens each frame. The enables and the set of active sub-arrays are captured at that tick.

When time stamping is on, the frame begins with a 32-bit header that carries a free-running slot count. The lag words of the active sub-arrays follow. Each sub-array is drained in turn, from the lowest index up, until its stream marks its final word. When padding is on, zero words then fill the frame to exactly `FRAME_WORDS` lag words. A zero can serve as filler because a genuine lag result is never zero. With both features off, the output carries only the raw lag words, which matches the older format.

The output is a valid/ready word stream, and `outLast` tags the final word of each frame. If a new tick arrives before the current frame has completed, the framer drops the rest of that frame, starts the new one, and sets a sticky overflow flag.

Top module: `lag_framer`

## Requirements
- R1: After reset, `outValid`, `outLast`, `overflow` and every `subReady` bit are 0, and the first header sent carries the value 0.
- R2: With time stamping on, the first word of a frame is a 32-bit count of the slot ticks seen before the tick that opened the frame, so consecutive headers differ by one per tick.
- R3: Lag words are taken only from sub-arrays whose `activeMask` bit was set at the tick. They are taken in ascending index order, and each sub-array is drained up to and including the word it flags with `subLast`.
- R4: With padding on, each frame carries exactly `FRAME_WORDS` lag words (the header is not counted), and every word after the real data is 0.
- R5: With time stamping off, no header word is sent, and the frame starts directly with lag data or filler.
- R6: With both time stamping and padding off, only lag words are sent. A tick with no active sub-array then produces no output at all.
- R7: `outLast` is 1 on the final word of each completed frame and on no other word. Once a frame has completed, `outValid` stays 0 until the next tick.
- R8: A tick that arrives while a frame is still incomplete sets `overflow`, which then stays set until reset. The unfinished frame is abandoned and the new frame starts with its own header.
- R9: While `outValid` is 1 and `outReady` is 0, the output word holds. At most one `subReady` bit is 1, and only while `outReady` is 1.
- R10: Changing `stampEn`, `padEn` or `activeMask` after the tick has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotTick | input | 1 | One-cycle pulse that opens a dump slot |
| stampEn | input | 1 | Send a header word (captured at the tick) |
| padEn | input | 1 | Zero-fill to `FRAME_WORDS` lag words (captured at the tick) |
| activeMask | input | NUM_SUB | Sub-arrays with results in this slot (captured at the tick) |
| subData | input | NUM_SUB*32 | Lag word of each sub-array, sub-array i in bits [32i+31:32i] |
| subValid | input | NUM_SUB | Lag word valid, per sub-array |
| subLast | input | NUM_SUB | Final lag word of the sub-array for this slot |
| subReady | output | NUM_SUB | Lag word accepted, per sub-array |
| outData | output | 32 | Frame word: header, lag or zero filler |
| outValid | output | 1 | Frame word valid |
| outLast | output | 1 | Final word of the frame |
| outReady | input | 1 | Downstream accepts the word |
| overflow | output | 1 | Sticky: a tick cut a frame short |

## Verification
The embedded assertions check the following on every cycle:
- the overflow flag never clears once set;
- at most one sub-array is granted at a time, and only while the sink is ready;
- a stalled header or filler word is held;
- `outLast` never appears without `outValid`;
- the filler stays inside its budget;
- the slot count advances by one at each tick.

Only the scenarios in the bench can show the following:
- the frame contents (header values, the order of sub-arrays and the exact filler count) under different enable combinations and under random back-pressure;
- the truncation that follows an early tick;
- that mask and enable changes made in the middle of a frame have no effect.

// File: rtl/lag_framer_pkg.sv
package lag_framer_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_PAD
  } frameState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // slot tick: capture header, clear lag count
    logic selHdr;   // output the header word
    logic selData;  // output the current sub-array word
    logic selPad;   // output a zero filler word
    logic fire;     // output word transferred this cycle
  } frameCtl_t;
endpackage

// File: rtl/lag_framer_dp.sv
module lag_framer_dp
  import lag_framer_pkg::*;
#(
  parameter int FRAME_WORDS = 262144,
  parameter int NUM_SUB     = 4,
  parameter int IDX_W       = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  frameCtl_t                 ctl,
  input  logic [IDX_W-1:0]          curIdx,
  input  logic [NUM_SUB*WORD_W-1:0] subData,
  output logic [WORD_W-1:0]         outData,
  output logic                      lagAtEnd
);
  localparam int CNT_W = $clog2(FRAME_WORDS + 1);

  logic [WORD_W-1:0] slotCnt;
  logic [WORD_W-1:0] hdrVal;
  logic [CNT_W-1:0]  lagCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
      hdrVal  <= '0;
      lagCnt  <= '0;
    end else if (ctl.start) begin
      hdrVal  <= slotCnt;
      slotCnt <= slotCnt + 1'b1;
      lagCnt  <= '0;
    end else if (ctl.fire && (ctl.selData || ctl.selPad)) begin
      lagCnt <= lagCnt + 1'b1;
    end
  end

  assign lagAtEnd = (lagCnt == CNT_W'(FRAME_WORDS - 1));

  always_comb begin
    if (ctl.selHdr)       outData = hdrVal;
    else if (ctl.selData) outData = subData[int'(curIdx)*WORD_W +: WORD_W];
    else                  outData = '0;
  end

  AST_PAD_IN_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selPad |-> (lagCnt < CNT_W'(FRAME_WORDS))); // R4
  AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |=> (slotCnt == hdrVal + 1'b1)); // R2
endmodule

// File: rtl/lag_framer_ctl.sv
module lag_framer_ctl
  import lag_framer_pkg::*;
#(
  parameter int NUM_SUB = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               slotTick,
  input  logic               stampEn,
  input  logic               padEn,
  input  logic [NUM_SUB-1:0] activeMask,
  input  logic [NUM_SUB-1:0] subValid,
  input  logic [NUM_SUB-1:0] subLast,
  input  logic               outReady,
  input  logic               lagAtEnd,
  output frameCtl_t          ctl,
  output logic [IDX_W-1:0]   curIdx,
  output logic [NUM_SUB-1:0] subReady,
  output logic               outValid,
  output logic               outLast,
  output logic               overflow
);
  frameState_t        state, nextState;
  logic [NUM_SUB-1:0] pending, nextPending, pendingRest;
  logic               padQ, nextPad;
  logic               fire, finishing, busy;

  // lowest pending sub-array is served first
  always_comb begin
    curIdx = '0;
    for (int i = NUM_SUB - 1; i >= 0; i--) begin
      if (pending[i]) curIdx = IDX_W'(i);
    end
  end

  assign pendingRest = pending & ~(NUM_SUB'(1) << curIdx);

  always_comb begin
    outValid = 1'b0;
    outLast  = 1'b0;
    subReady = '0;
    ctl      = '0;
    case (state)
      ST_HDR: begin
        ctl.selHdr = 1'b1;
        outValid   = 1'b1;
        outLast    = (pending == '0) && !padQ;
      end
      ST_DATA: begin
        ctl.selData      = 1'b1;
        outValid         = subValid[curIdx];
        outLast          = subValid[curIdx] && subLast[curIdx] &&
                           (pendingRest == '0) && (!padQ || lagAtEnd);
        subReady[curIdx] = outReady;
      end
      ST_PAD: begin
        ctl.selPad = 1'b1;
        outValid   = 1'b1;
        outLast    = lagAtEnd;
      end
      default: ;
    endcase
    fire      = outValid && outReady;
    ctl.fire  = fire;
    ctl.start = slotTick;
  end

  assign finishing = fire && outLast;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    nextState   = state;
    nextPending = pending;
    nextPad     = padQ;
    if (slotTick) begin
      nextPending = activeMask;
      nextPad     = padEn;
      if (stampEn)              nextState = ST_HDR;
      else if (activeMask != 0) nextState = ST_DATA;
      else if (padEn)           nextState = ST_PAD;
      else                      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_HDR: if (fire) begin
          if (pending != '0) nextState = ST_DATA;
          else if (padQ)     nextState = ST_PAD;
          else               nextState = ST_IDLE;
        end
        ST_DATA: if (fire && subLast[curIdx]) begin
          nextPending = pendingRest;
          if (pendingRest != '0) nextState = ST_DATA;
          else if (finishing)    nextState = ST_IDLE;
          else                   nextState = ST_PAD;
        end
        ST_PAD: if (finishing) nextState = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pending  <= '0;
      padQ     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      state   <= nextState;
      pending <= nextPending;
      padQ    <= nextPad;
      if (slotTick && busy && !finishing) overflow <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(subReady)); // R9
  AST_GRANT_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rstN)
    (subReady != '0) |-> outReady); // R9
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !slotTick && state != ST_DATA) |=> (outValid && $stable(state))); // R9
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R7
endmodule

// File: rtl/lag_framer.sv
module lag_framer
  import lag_framer_pkg::*;
#(
  parameter int NUM_SUB     = 4,
  parameter int FRAME_WORDS = 262144
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      slotTick,
  input  logic                      stampEn,
  input  logic                      padEn,
  input  logic [NUM_SUB-1:0]        activeMask,
  input  logic [NUM_SUB*WORD_W-1:0] subData,
  input  logic [NUM_SUB-1:0]        subValid,
  input  logic [NUM_SUB-1:0]        subLast,
  output logic [NUM_SUB-1:0]        subReady,
  output logic [WORD_W-1:0]         outData,
  output logic                      outValid,
  output logic                      outLast,
  input  logic                      outReady,
  output logic                      overflow
);
  localparam int IDX_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1;

  frameCtl_t        ctl;
  logic [IDX_W-1:0] curIdx;
  logic             lagAtEnd;

  lag_framer_ctl #(.NUM_SUB(NUM_SUB), .IDX_W(IDX_W)) uCtl (
    .clk(clk), .rstN(rstN), .slotTick(slotTick), .stampEn(stampEn),
    .padEn(padEn), .activeMask(activeMask), .subValid(subValid),
    .subLast(subLast), .outReady(outReady), .lagAtEnd(lagAtEnd),
    .ctl(ctl), .curIdx(curIdx), .subReady(subReady), .outValid(outValid),
    .outLast(outLast), .overflow(overflow)
  );

  lag_framer_dp #(.FRAME_WORDS(FRAME_WORDS), .NUM_SUB(NUM_SUB), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curIdx(curIdx), .subData(subData),
    .outData(outData), .lagAtEnd(lagAtEnd)
  );
endmodule

// File: tb/tb_lag_framer.sv
module tb_lag_framer;
  localparam int NSUB = 4;
  localparam int FW   = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN = 1'b0, slotTick = 1'b0, stampEn = 1'b0, padEn = 1'b0;
  logic [NSUB-1:0]   activeMask = '0, subValid = '0, subLast = '0, subReady;
  logic [NSUB*32-1:0] subData = '0;
  logic [31:0]       outData;
  logic              outValid, outLast, overflow;
  logic              outReady = 1'b1;

  lag_framer #(.NUM_SUB(NSUB), .FRAME_WORDS(FW)) dut (
    .clk(clk), .rstN(rstN), .slotTick(slotTick), .stampEn(stampEn), .padEn(padEn),
    .activeMask(activeMask), .subData(subData), .subValid(subValid), .subLast(subLast),
    .subReady(subReady), .outData(outData), .outValid(outValid), .outLast(outLast),
    .outReady(outReady), .overflow(overflow)
  );

  typedef struct { logic [31:0] d; logic l; string req; } exp_t;
  exp_t expQ[$];
  exp_t e;
  logic [31:0] srcD[NSUB][$];
  logic        srcL[NSUB][$];
  bit   popF[NSUB];
  int   tests = 0, fails = 0, tickCnt = 0;
  bit   rdyRand = 0, holdReady = 0, finished = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // monitor: compare every transferred word against the scoreboard
  always @(negedge clk) if (rstN) begin
    chk("R9 grant", {31'b0, ($countones(subReady) <= 1) && (subReady == '0 || outReady)}, 32'd1);
    if (outValid && outReady) begin
      if (expQ.size() == 0) begin
        chk("R7 unexpected word", outData, 32'hFFFF_FFFF);
      end else begin
        e = expQ.pop_front();
        chk(e.req, outData, e.d);
        chk("R7 last flag", {31'b0, outLast}, {31'b0, e.l});
      end
    end
    for (int i = 0; i < NSUB; i++) popF[i] = subValid[i] && subReady[i];
  end

  // sources and sink readiness, updated just after each edge
  always @(posedge clk) begin
    #1;
    for (int i = 0; i < NSUB; i++) begin
      if (popF[i] && srcD[i].size() > 0) begin
        void'(srcD[i].pop_front());
        void'(srcL[i].pop_front());
      end
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = holdReady ? 1'b0 : (rdyRand ? lfsr[0] : 1'b1);
    for (int i = 0; i < NSUB; i++) begin
      subValid[i] = srcD[i].size() > 0;
      subData[i*32 +: 32] = (srcD[i].size() > 0) ? srcD[i][0] : 32'h0;
      subLast[i] = (srcL[i].size() > 0) ? srcL[i][0] : 1'b0;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    slotTick = 1'b1;
    @(posedge clk); #2;
    slotTick = 1'b0;
    tickCnt++;
  endtask

  task automatic waitDone(string req);
    int t = 0;
    while (expQ.size() > 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk({req, " frame complete"}, expQ.size(), 0);
    repeat (3) @(negedge clk);
    chk("R7 idle after frame", {31'b0, outValid}, 32'd0);
  endtask

  // driver: load sources and push expected frame, then open the slot
  task automatic loadSlot(logic [NSUB-1:0] mask, bit ts, bit pad, int lens[NSUB]);
    int n = 0;
    exp_t x;
    if (ts) begin x.d = tickCnt; x.l = 0; x.req = "R2 header"; expQ.push_back(x); end
    for (int i = 0; i < NSUB; i++) begin
      if (mask[i]) begin
        for (int k = 0; k < lens[i]; k++) begin
          x.d = 32'h1000 * (i + 1) + k + 1; x.l = 0; x.req = "R3 order";
          srcD[i].push_back(x.d);
          srcL[i].push_back(k == lens[i] - 1);
          expQ.push_back(x);
          n++;
        end
      end
    end
    if (pad) begin
      for (int k = n; k < FW; k++) begin x.d = 0; x.l = 0; x.req = "R4 pad"; expQ.push_back(x); end
    end
    if (expQ.size() > 0) expQ[expQ.size()-1].l = 1'b1;
    @(posedge clk); #2;
    activeMask = mask; stampEn = ts; padEn = pad;
  endtask

  initial begin
    #(10 * 150000);
    chk("watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outValid", {31'b0, outValid}, 32'd0);
    chk("R1 outLast", {31'b0, outLast}, 32'd0);
    chk("R1 overflow", {31'b0, overflow}, 32'd0);
    chk("R1 subReady", {28'b0, subReady}, 32'd0);

    // R1 R2 R3 R4: header 0, sub0 and sub2 in order, zero fill
    loadSlot(4'b0101, 1, 1, '{3, 0, 2, 0}); tick(); waitDone("R4");

    // R3 R7: all subs, header only, random back-pressure
    rdyRand = 1;
    loadSlot(4'b1111, 1, 0, '{1, 2, 1, 3}); tick(); waitDone("R3");

    // R5: padding without header
    loadSlot(4'b0010, 0, 1, '{0, 4, 0, 0}); tick(); waitDone("R5");

    // R6: neither feature, raw data only
    loadSlot(4'b1001, 0, 0, '{2, 0, 0, 1}); tick(); waitDone("R6");

    // R6: nothing active, nothing enabled: no output
    loadSlot(4'b0000, 0, 0, '{0, 0, 0, 0}); tick();
    repeat (6) begin
      @(negedge clk);
      chk("R6 silent slot", {31'b0, outValid}, 32'd0);
    end

    // R4: header plus full filler
    loadSlot(4'b0000, 1, 1, '{0, 0, 0, 0}); tick(); waitDone("R4");

    // R10: captured settings ignore later changes
    loadSlot(4'b0001, 1, 1, '{2, 0, 0, 0}); tick();
    activeMask = 4'b1111; padEn = 1'b0; stampEn = 1'b0;
    srcD[1].push_back(32'h7777); srcL[1].push_back(1'b1);
    waitDone("R10");
    chk("R10 unlisted sub untouched", srcD[1].size(), 1);
    srcD[1].delete(); srcL[1].delete();
    chk("R8 no overflow yet", {31'b0, overflow}, 32'd0);

    // R8 R9: stall the header, then an early tick truncates
    holdReady = 1; rdyRand = 0;
    activeMask = '0; stampEn = 1'b1; padEn = 1'b1;
    tick();
    repeat (3) begin
      @(negedge clk);
      chk("R9 stalled valid", {31'b0, outValid}, 32'd1);
      chk("R9 stalled word", outData, tickCnt - 1);
    end
    chk("R8 before early tick", {31'b0, overflow}, 32'd0);
    loadSlot(4'b0000, 1, 1, '{0, 0, 0, 0});
    tick();
    @(negedge clk);
    chk("R8 overflow set", {31'b0, overflow}, 32'd1);
    holdReady = 0; rdyRand = 1;
    waitDone("R8");
    chk("R8 overflow sticky", {31'b0, overflow}, 32'd1);

    finish_run();
  end
endmodule